// File: doc/BRIEF.md
# Radix-2 Delay-Feedback Butterfly Stage

This block is one radix-2 butterfly stage of a pipelined FFT built on the single-path delay-feedback scheme. Complex samples enter one per clock, in natural order, qualified by `in_valid`. A block of 2·DEPTH samples is handled in two halves. During the first half the samples are parked in an internal feedback delay line. During the second half each new sample is paired with the sample that entered DEPTH positions earlier. The scaled sum leaves the stage at once, and the scaled difference goes back into the delay line.

The parked differences leave the stage later. If the next block is already arriving, one difference leaves for each new sample that is written. If the input is idle, they leave on their own on consecutive cycles. The stage builds its own output strobe from a local input counter and a drain counter, so the next stage in the pipe needs no other control. Each component of a sum or difference is computed one bit wider, then shifted right arithmetically by one bit (floor division by two). This makes overflow impossible at the fixed width. Gaps in `in_valid` stall the stage without disturbing the pairing.

Top module: `sdf_r2_stage`

## Requirements
- R1: While reset is asserted, and for the first DEPTH valid inputs of the first block after reset, `out_valid` stays 0.
- R2: For a block x[0..2·DEPTH-1], the n-th output of the block (n < DEPTH) is floor((x[n]+x[n+DEPTH])/2) for both the real and imaginary parts. It is presented with `out_valid`=1 in the cycle after x[n+DEPTH] is accepted.
- R3: Outputs DEPTH..2·DEPTH-1 of a block are floor((x[n]-x[n+DEPTH])/2), in order n = 0..DEPTH-1.
- R4: Cycles with `in_valid`=0 inside a block do not change any output value or the pairing. While the stage is pairing samples, no output appears in the cycle after an idle input cycle.
- R5: If no new block begins, the DEPTH differences appear on consecutive cycles, starting in the cycle right after the last sum.
- R6: When blocks arrive back to back with no gaps, the output stream has no gaps: the sums of block k, then its differences, then the sums of block k+1, one output per cycle.
- R7: Each block produces exactly 2·DEPTH outputs with `out_valid`=1. After the differences have drained, `out_valid` stays 0 while the input is idle.
- R8: Full-scale two's-complement inputs (-2^(W-1) and 2^(W-1)-1) give correctly scaled results with no wrap-around.
- R9: A reset in the middle of a block discards that partial block. The next block after reset is processed as if it were the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_re | input | DATA_W | Input real part, two's complement |
| in_im | input | DATA_W | Input imaginary part, two's complement |
| out_valid | output | 1 | Registered output qualifier |
| out_re | output | DATA_W | Output real part, two's complement |
| out_im | output | DATA_W | Output imaginary part, two's complement |

## Verification
The bench builds the stage with DATA_W=12 and DEPTH=4, so one block has eight samples. With that block size, back-to-back blocks, gapped blocks and self-draining can all be run in a few dozen cycles. A 12-bit width makes the full-scale corners -2048 and 2047 easy to hit and to compare exactly against a floor-halved integer model. A DEPTH of 4 still wraps the delay-line pointer several times per block, so any off-by-one in the pointer or the counters shows up as a wrong pairing.

// File: rtl/sdf_r2_pkg.sv
package sdf_r2_pkg;

  // Phase of the feedback loop: parking samples or pairing them.
  typedef enum logic {
    PH_FILL = 1'b0,
    PH_BFLY = 1'b1
  } sdf_phase_e;

endpackage

// File: rtl/sdf_delay_line.sv
// Circular-buffer delay line of DEPTH words. It is equivalent to a DEPTH-long
// shift register: the word read at the pointer is the one written DEPTH
// advances earlier. Written as a RAM with a single address so that it maps to
// memory rather than to a register chain.
module sdf_delay_line #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     ptr;

  assign rd_word = mem[ptr];

  always_ff @(posedge clk) begin
    if (shift) begin
      mem[ptr] <= wr_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (shift) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

endmodule

// File: rtl/sdf_bfly_arith.sv
// Scaled radix-2 butterfly: sum and difference computed one bit wider, then
// halved with an arithmetic shift. One generate lane per complex component.
module sdf_bfly_arith #(
  parameter int DATA_W = 16
) (
  input  logic [1:0][DATA_W-1:0] a,
  input  logic [1:0][DATA_W-1:0] b,
  output logic [1:0][DATA_W-1:0] sum_half,
  output logic [1:0][DATA_W-1:0] dif_half
);

  localparam int EXT_W = DATA_W + 1;

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic signed [EXT_W-1:0] a_ext;
    logic signed [EXT_W-1:0] b_ext;
    logic signed [EXT_W-1:0] sum_ext;
    logic signed [EXT_W-1:0] dif_ext;

    always_comb begin
      a_ext   = {a[lane][DATA_W-1], a[lane]};
      b_ext   = {b[lane][DATA_W-1], b[lane]};
      sum_ext = a_ext + b_ext;
      dif_ext = a_ext - b_ext;
    end

    assign sum_half[lane] = sum_ext[EXT_W-1:1];
    assign dif_half[lane] = dif_ext[EXT_W-1:1];
  end

endmodule

// File: rtl/sdf_stage_ctrl.sv
// Local control: the input counter picks the loop phase, and a drain counter
// tracks how many stored differences are still to leave the stage.
module sdf_stage_ctrl
  import sdf_r2_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  output sdf_phase_e                        phase,
  output logic                              at_start,
  output logic [$clog2(2*DEPTH)-1:0]        drain_left,
  output logic                              advance,
  output logic                              emit
);

  localparam int CW = $clog2(2 * DEPTH);
  localparam logic [CW-1:0] DRAIN_INIT = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_LAST   = {CW{1'b1}};

  logic [CW-1:0] in_cnt;
  logic          drain_pop;
  logic          last_in;

  always_comb begin
    phase     = in_cnt[CW-1] ? PH_BFLY : PH_FILL;
    at_start  = (in_cnt == '0);
    drain_pop = (phase == PH_FILL) && (drain_left != '0) && (in_valid || at_start);
    advance   = in_valid || drain_pop;
    emit      = ((phase == PH_BFLY) && in_valid) || drain_pop;
    last_in   = in_valid && (in_cnt == CNT_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cnt     <= '0;
      drain_left <= '0;
    end else begin
      if (in_valid) begin
        in_cnt <= in_cnt + 1'b1;
      end
      if (last_in) begin
        drain_left <= DRAIN_INIT;
      end else if (drain_pop) begin
        drain_left <= drain_left - 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdf_r2_stage.sv
module sdf_r2_stage
  import sdf_r2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_re,
  output logic [DATA_W-1:0] out_im
);

  localparam int CW     = $clog2(2 * DEPTH);
  localparam int WORD_W = 2 * DATA_W;

  sdf_phase_e               phase;
  logic                     at_start;
  logic [CW-1:0]            drain_left;
  logic                     advance;
  logic                     emit;
  logic                     bfly_phase;
  logic                     drain_busy;

  logic [WORD_W-1:0]        head_word;
  logic [WORD_W-1:0]        fb_word;
  logic [1:0][DATA_W-1:0]   head_c;
  logic [1:0][DATA_W-1:0]   in_c;
  logic [1:0][DATA_W-1:0]   sum_c;
  logic [1:0][DATA_W-1:0]   dif_c;

  sdf_stage_ctrl #(
    .DEPTH (DEPTH)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .phase      (phase),
    .at_start   (at_start),
    .drain_left (drain_left),
    .advance    (advance),
    .emit       (emit)
  );

  // Real part in the upper half of the stored word, imaginary in the lower.
  assign head_c[1] = head_word[WORD_W-1:DATA_W];
  assign head_c[0] = head_word[DATA_W-1:0];
  assign in_c[1]   = in_re;
  assign in_c[0]   = in_im;

  sdf_bfly_arith #(
    .DATA_W (DATA_W)
  ) u_arith (
    .a        (head_c),
    .b        (in_c),
    .sum_half (sum_c),
    .dif_half (dif_c)
  );

  assign bfly_phase = (phase == PH_BFLY);
  assign drain_busy = (drain_left != '0);
  assign fb_word    = bfly_phase ? {dif_c[1], dif_c[0]} : {in_re, in_im};

  sdf_delay_line #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH)
  ) u_dline (
    .clk     (clk),
    .rst     (rst),
    .shift   (advance),
    .wr_word (fb_word),
    .rd_word (head_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_re <= bfly_phase ? sum_c[1] : head_c[1];
        out_im <= bfly_phase ? sum_c[0] : head_c[0];
      end
    end
  end

endmodule

// File: rtl/sdf_r2_stage_chk.sv
module sdf_r2_stage_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid,
  input logic bfly_phase,
  input logic at_start,
  input logic drain_busy
);

  assert_fill_silent_R1: assert property (@(posedge clk) disable iff (rst)
    (!bfly_phase && !drain_busy) |=> !out_valid);

  assert_pair_emits_R2: assert property (@(posedge clk) disable iff (rst)
    (bfly_phase && in_valid) |=> out_valid);

  assert_stall_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (bfly_phase && !in_valid) |=> !out_valid);

  assert_self_drain_R5: assert property (@(posedge clk) disable iff (rst)
    (!bfly_phase && drain_busy && at_start) |=> out_valid);

  assert_fill_pops_R6: assert property (@(posedge clk) disable iff (rst)
    (!bfly_phase && drain_busy && in_valid) |=> out_valid);

endmodule

bind sdf_r2_stage sdf_r2_stage_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .bfly_phase (bfly_phase),
  .at_start   (at_start),
  .drain_busy (drain_busy)
);

// File: tb/sdf_r2_stage_bench.sv
module sdf_r2_stage_bench;

  localparam int BW  = 12;
  localparam int BD  = 4;
  localparam int BLK = 2 * BD;
  localparam int CAP = 64;

  localparam int TAB_RE [BLK] = '{100, -200, 300, -50, 7, -9, 2000, -2048};
  localparam int TAB_IM [BLK] = '{-1, 5, -300, 1024, 33, -77, -2048, 2047};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [BW-1:0] in_re = '0;
  logic [BW-1:0] in_im = '0;
  logic          out_valid;
  logic [BW-1:0] out_re;
  logic [BW-1:0] out_im;

  always #4 clk = ~clk;

  sdf_r2_stage #(.DATA_W(BW), .DEPTH(BD)) u_sdf_r2_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int ncap     = 0;
  int got_re [CAP];
  int got_im [CAP];
  int got_cyc[CAP];
  int stim_re[2*BLK];
  int stim_im[2*BLK];
  int exp_re [CAP];
  int exp_im [CAP];
  int nexp;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && ncap < CAP) begin
      got_re[ncap]  = int'($signed(out_re));
      got_im[ncap]  = int'($signed(out_im));
      got_cyc[ncap] = cyc;
      ncap = ncap + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int re, input int im);
    @(negedge clk);
    in_valid = v;
    in_re    = re[BW-1:0];
    in_im    = im[BW-1:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 0);
  endtask

  task automatic clear_cap();
    @(posedge clk);
    ncap = 0;
    nexp = 0;
  endtask

  // Append the expected sums then differences of block starting at stim[base].
  task automatic expect_block(input int base);
    for (int n = 0; n < BD; n++) begin
      exp_re[nexp] = (stim_re[base+n] + stim_re[base+n+BD]) >>> 1;
      exp_im[nexp] = (stim_im[base+n] + stim_im[base+n+BD]) >>> 1;
      nexp++;
    end
    for (int n = 0; n < BD; n++) begin
      exp_re[nexp] = (stim_re[base+n] - stim_re[base+n+BD]) >>> 1;
      exp_im[nexp] = (stim_im[base+n] - stim_im[base+n+BD]) >>> 1;
      nexp++;
    end
  endtask

  task automatic compare(input string req);
    check({req, " output count (R7)"}, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      check({req, (i % BLK) < BD ? " sum R2" : " diff R3"}, got_re[i], exp_re[i]);
      check({req, (i % BLK) < BD ? " sum R2" : " diff R3"}, got_im[i], exp_im[i]);
    end
  endtask

  task automatic load_table();
    for (int i = 0; i < BLK; i++) begin
      stim_re[i] = TAB_RE[i];
      stim_im[i] = TAB_IM[i];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", int'(out_valid), 0);
    rst = 1'b0;

    // R1: first half of the block gives no output.
    load_table();
    clear_cap();
    for (int i = 0; i < BD; i++) drive(1'b1, stim_re[i], stim_im[i]);
    idle(1);
    check("R1 silent during fill", ncap, 0);

    // Table walk: contiguous block, then idle so differences self-drain.
    for (int i = BD; i < BLK; i++) drive(1'b1, stim_re[i], stim_im[i]);
    idle(3 * BD);
    expect_block(0);
    compare("table");
    for (int j = 1; j < BLK && j < ncap; j++)
      check("R5 consecutive drain cycles", got_cyc[j] - got_cyc[j-1], 1);
    idle(BLK);
    check("R7 quiet after drain", ncap, BLK);

    // R4: gap after every input.
    clear_cap();
    for (int i = 0; i < BLK; i++) begin
      drive(1'b1, stim_re[i], stim_im[i]);
      drive(1'b0, 0, 0);
    end
    idle(3 * BD);
    expect_block(0);
    compare("R4 gapped");
    if (ncap > 1) check("R4 stall spacing", got_cyc[1] - got_cyc[0], 2);

    // R6: two blocks back to back.
    clear_cap();
    for (int i = 0; i < BLK; i++) begin
      stim_re[BLK+i] = TAB_IM[i] >>> 1;
      stim_im[BLK+i] = TAB_RE[i] >>> 1;
    end
    for (int i = 0; i < 2 * BLK; i++) drive(1'b1, stim_re[i], stim_im[i]);
    idle(3 * BD);
    expect_block(0);
    expect_block(BLK);
    compare("R6 back-to-back");
    for (int j = 1; j < 2 * BLK && j < ncap; j++)
      check("R6 gapless stream", got_cyc[j] - got_cyc[0], j);

    // R8: full-scale corners.
    clear_cap();
    for (int i = 0; i < BLK; i++) begin
      stim_re[i] = (i < BD) ? 2047 : -2048;
      stim_im[i] = (i < BD) ? -2048 : -2048;
    end
    for (int i = 0; i < BLK; i++) drive(1'b1, stim_re[i], stim_im[i]);
    idle(3 * BD);
    expect_block(0);
    compare("R8 full-scale");
    check("R8 sum re", got_re[0], -1);
    check("R8 sum im", got_im[0], -2048);
    check("R8 diff re", got_re[BD], 2047);

    // R9: reset in the middle of a block.
    clear_cap();
    for (int i = 0; i < 3; i++) drive(1'b1, 1500, -1500);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 reset out_valid", int'(out_valid), 0);
    rst = 1'b0;
    load_table();
    for (int i = 0; i < BLK; i++) drive(1'b1, stim_re[i], stim_im[i]);
    idle(3 * BD);
    expect_block(0);
    compare("R9 after mid-block reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule